// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Target

This block is a target on an I2C bus that can only receive. A fast system clock oversamples the SCL and SDA lines. Each line goes through a synchroniser and a stable-run filter, and an edge detector then finds the bus conditions. A framing state machine shifts in the address byte and the data bytes that follow it.

The block takes part on the bus in one way only: it pulls SDA low during the acknowledge clock of a byte it accepts. It accepts a write addressed to its parameterised 7-bit address and every data byte of that write. It never accepts a read, and never accepts a transfer to another address. In both of those cases it leaves the ninth clock undriven and stays silent until the next START or STOP.

Each accepted data byte appears for one system cycle on a strobe output, together with its value and its position since the most recent START.

Top module: `i2c_rx_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins address reception. A STOP (SDA rises while SCL is high) returns the block to idle, and bytes clocked after a STOP without a new START are neither acknowledged nor strobed.
- R2: A START that arrives before a STOP (a repeated START) restarts address reception at once. The block does not pass through idle.
- R3: For a write to DEV_ADDR, the first byte on the bus is the address (bits 7..1) followed by R/W = 0 (bit 0), sent MSB first. The block asserts `sda_pull_o` after the SCL fall that ends bit 8 and holds it across the ninth clock. It releases it after the SCL fall that ends the ninth clock.
- R4: An address byte that matches DEV_ADDR but carries R/W = 1 gets no acknowledge. After it, nothing is acknowledged or strobed until the next START or STOP.
- R5: An address byte whose upper seven bits differ from DEV_ADDR gets no acknowledge, and the rest of that transfer is ignored.
- R6: Every data byte of an accepted write is acknowledged. Its value, assembled MSB first from SDA sampled on SCL rising edges, appears on `byte_data_o` with `byte_vld_o` high for exactly one clock.
- R7: `byte_idx_o` gives the number of data bytes accepted before this one since the latest START or repeated START. The first byte after a START gets index 0.
- R8: A STOP or a START that cuts a byte short discards the partial byte, and no strobe is produced for it.
- R9: `sda_pull_o` is low out of reset, and outside acknowledge clocks it is low at all times.
- R10: A level change on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect: it adds no bit and creates no condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| byte_vld_o | output | 1 | One-cycle strobe for an accepted data byte |
| byte_data_o | output | 8 | Value of the accepted data byte |
| byte_idx_o | output | IDX_W | Position of the byte since the latest START |

## Verification
The assertions check, on every cycle, the properties that hold locally. The pull-down is only ever active in an acknowledge state, and it is held until an SCL fall, STOP or START. A strobe never lasts two cycles and never follows a STOP. The index clears after each START. A filtered line only takes a value that the synchroniser has shown. Only the bench scenarios can show the results that depend on a whole transaction: address and R/W decoding, refusing reads and foreign addresses until the next condition, byte values and indices across repeated STARTs, dropping truncated bytes, and ignoring short glitches on both lines.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_e;

    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/i2c_rx_glitch.sv
module i2c_rx_glitch #(
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
    localparam int unsigned TOP   = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       run;
        logic                   level;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[SYNC_STAGES-2:0], raw_i};
        if (flt_q.sync[TOP] != flt_q.level) begin
            if (flt_q.run == CNT_W'(FILT_LEN - 1)) begin
                flt_d.level = flt_q.sync[TOP];
                flt_d.run   = '0;
            end else begin
                flt_d.run = flt_q.run + CNT_W'(1);
            end
        end else begin
            flt_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.sync  <= '1;
            flt_q.run   <= '0;
            flt_q.level <= 1'b1;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign clean_o = flt_q.level;

    // R10
    level_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.level != $past(flt_q.level)) |-> ($past(flt_q.sync[TOP]) == flt_q.level));

endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_i;
        prev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    always_comb begin
        start_o = scl_i & prev_q.scl & prev_q.sda & ~sda_i;
        stop_o  = scl_i & prev_q.scl & ~prev_q.sda & sda_i;
        rise_o  = scl_i & ~prev_q.scl;
        fall_o  = ~scl_i & prev_q.scl;
    end

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import i2c_rx_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h52,
    parameter int unsigned IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             sda_i,
    output logic             pull_o,
    output logic             vld_o,
    output logic [7:0]       data_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        rx_state_e        state;
        logic [7:0]       shreg;
        logic [3:0]       bits;
        logic             ack;
        logic [IDX_W-1:0] idx;
        logic             vld;
        logic [7:0]       data;
        logic [IDX_W-1:0] out_idx;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.vld = 1'b0;
        if (stop_i) begin
            fsm_d.state = ST_IDLE;
            fsm_d.ack   = 1'b0;
        end else if (start_i) begin
            fsm_d.state = ST_ADDR;
            fsm_d.bits  = '0;
            fsm_d.ack   = 1'b0;
            fsm_d.idx   = '0;
        end else begin
            case (fsm_q.state)
                ST_ADDR, ST_DATA: begin
                    if (rise_i && fsm_q.bits != 4'(BYTE_BITS)) begin
                        fsm_d.shreg = {fsm_q.shreg[6:0], sda_i};
                        fsm_d.bits  = fsm_q.bits + 4'd1;
                    end
                    if (fall_i && fsm_q.bits == 4'(BYTE_BITS)) begin
                        if (fsm_q.state == ST_ADDR) begin
                            if (fsm_q.shreg[7:1] == DEV_ADDR && !fsm_q.shreg[0]) begin
                                fsm_d.ack   = 1'b1;
                                fsm_d.state = ST_ADDR_ACK;
                            end else begin
                                fsm_d.state = ST_SKIP;
                            end
                        end else begin
                            fsm_d.ack     = 1'b1;
                            fsm_d.state   = ST_DATA_ACK;
                            fsm_d.vld     = 1'b1;
                            fsm_d.data    = fsm_q.shreg;
                            fsm_d.out_idx = fsm_q.idx;
                            fsm_d.idx     = fsm_q.idx + IDX_W'(1);
                        end
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (fall_i) begin
                        fsm_d.ack   = 1'b0;
                        fsm_d.state = ST_DATA;
                        fsm_d.bits  = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, shreg: '0, bits: '0, ack: 1'b0,
                       idx: '0, vld: 1'b0, data: '0, out_idx: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign pull_o = fsm_q.ack;
    assign vld_o  = fsm_q.vld;
    assign data_o = fsm_q.data;
    assign idx_o  = fsm_q.out_idx;

    // R9
    pull_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.ack |-> (fsm_q.state == ST_ADDR_ACK || fsm_q.state == ST_DATA_ACK));

    // R3
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.ack && !fall_i && !stop_i && !start_i) |=> fsm_q.ack);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.vld |=> !fsm_q.vld);

    // R7
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (fsm_q.idx == '0));

    // R8
    no_strobe_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !fsm_q.vld);

    // R4
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_SKIP) |-> !fsm_q.ack);

endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave #(
    parameter logic [6:0]  DEV_ADDR    = 7'h52,
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic             byte_vld_o,
    output logic [7:0]       byte_data_o,
    output logic [IDX_W-1:0] byte_idx_o
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] clean;
    logic start, stop, rise, fall;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_rx_glitch #(
            .FILT_LEN   (FILT_LEN),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[g]),
            .clean_o(clean[g])
        );
    end

    i2c_rx_cond u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (clean[0]),
        .sda_i  (clean[1]),
        .start_o(start),
        .stop_o (stop),
        .rise_o (rise),
        .fall_o (fall)
    );

    i2c_rx_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .IDX_W   (IDX_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .stop_i (stop),
        .rise_i (rise),
        .fall_i (fall),
        .sda_i  (clean[1]),
        .pull_o (sda_pull_o),
        .vld_o  (byte_vld_o),
        .data_o (byte_data_o),
        .idx_o  (byte_idx_o)
    );

endmodule

// File: tb/i2c_rx_slave_tb.sv
module i2c_rx_slave_tb;
    localparam logic [6:0] DEV = 7'h52;
    localparam int Q = 40;
    localparam int IDX_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull_o, byte_vld_o;
    logic [7:0] byte_data_o;
    logic [IDX_W-1:0] byte_idx_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_o;

    i2c_rx_slave #(.DEV_ADDR(DEV), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull_o), .byte_vld_o(byte_vld_o),
        .byte_data_o(byte_data_o), .byte_idx_o(byte_idx_o));

    logic [7:0] cap_data [64];
    int         cap_idx  [64];
    int         cap_n = 0;

    always @(negedge clk) begin
        if (byte_vld_o && cap_n < 64) begin
            cap_data[cap_n] <= byte_data_o;
            cap_idx[cap_n]  <= int'(byte_idx_o);
            cap_n           <= cap_n + 1;
        end
    end

    // {addr7, rw, count4, b0, b1, b2, expected_ack4}
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {7'h52, 1'b0, 4'd2, 8'hA5, 8'h3C, 8'h00, 4'd1},
        {7'h31, 1'b0, 4'd2, 8'hA4, 8'h11, 8'h00, 4'd0},
        {7'h52, 1'b1, 4'd2, 8'hA4, 8'hFF, 8'h00, 4'd0},
        {7'h52, 1'b0, 4'd3, 8'h00, 8'hFF, 8'h81, 4'd1},
        {7'h52, 1'b0, 4'd0, 8'h00, 8'h00, 8'h00, 4'd1},
        {7'h53, 1'b1, 4'd1, 8'hA4, 8'h00, 8'h00, 4'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                             input string req, input bit glitch);
        logic pulled;
        logic acked;
        pulled = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                repeat (10) @(negedge clk);
                scl_m = 1'b1;
                repeat (2) @(negedge clk);
                scl_m = 1'b0;
                repeat (Q - 12) @(negedge clk);
            end else begin
                wait_q();
            end
            scl_m = 1'b1;
            wait_q();
            if (sda_pull_o) pulled = 1'b1;
            if (glitch && i == 2) begin
                sda_m = ~b[i];
                repeat (2) @(negedge clk);
                sda_m = b[i];
                repeat (Q - 2) @(negedge clk);
            end else begin
                wait_q();
            end
            scl_m = 1'b0;
            wait_q();
        end
        check(!pulled, "R9", "pull during data bits", int'(pulled), 0);
        check(sda_pull_o == exp_ack, "R3", "pull after eighth fall",
              int'(sda_pull_o), int'(exp_ack));
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        acked = ~sda_line;
        check(acked == exp_ack, req, "ack on ninth clock", int'(acked), int'(exp_ack));
        wait_q();
        scl_m = 1'b0; wait_q();
        check(!sda_pull_o, "R3", "release after ninth fall", int'(sda_pull_o), 0);
    endtask

    task automatic expect_caps(input int base, input int n, input logic [23:0] dat,
                               input logic [11:0] idx, input string req);
        check(cap_n - base == n, req, "strobe count", cap_n - base, n);
        if (cap_n - base == n) begin
            for (int k = 0; k < n; k++) begin
                check(cap_data[base + k] == dat[23 - 8*k -: 8], "R6", "byte value",
                      int'(cap_data[base + k]), int'(dat[23 - 8*k -: 8]));
                check(cap_idx[base + k] == int'(idx[11 - 4*k -: 4]), "R7", "byte index",
                      cap_idx[base + k], int'(idx[11 - 4*k -: 4]));
            end
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (10) @(negedge clk);
        check(!sda_pull_o, "R9", "pull in reset", int'(sda_pull_o), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!sda_pull_o, "R9", "pull after reset", int'(sda_pull_o), 0);
        check(!byte_vld_o && cap_n == 0, "R6", "no strobe after reset", cap_n, 0);

        // table-driven transactions: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic [39:0] e;
            logic        ea;
            e    = VEC[v];
            ea   = e[0];
            base = cap_n;
            bus_start();
            send_byte(e[39:32], ea, e[32] ? "R4" : (e[39:33] != DEV ? "R5" : "R3"), 1'b0);
            for (int k = 0; k < int'(e[31:28]); k++)
                send_byte(e[27 - 8*k -: 8], ea, ea ? "R6" : "R4", 1'b0);
            bus_stop();
            expect_caps(base, ea ? int'(e[31:28]) : 0, e[27:4], 12'h012,
                        ea ? "R6" : "R5");
        end

        // R1: byte clocked after STOP with no START
        base = cap_n;
        send_byte({DEV, 1'b0}, 1'b0, "R1", 1'b0);
        send_byte(8'h99, 1'b0, "R1", 1'b0);
        bus_stop();
        expect_caps(base, 0, 24'h0, 12'h0, "R1");

        // R2 R7: repeated START resets the index
        base = cap_n;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R3", 1'b0);
        send_byte(8'h11, 1'b1, "R6", 1'b0);
        bus_rstart();
        send_byte({DEV, 1'b0}, 1'b1, "R2", 1'b0);
        send_byte(8'h22, 1'b1, "R2", 1'b0);
        send_byte(8'h33, 1'b1, "R2", 1'b0);
        bus_stop();
        expect_caps(base, 3, 24'h112233, 12'h001, "R2");

        // R4: repeated START into a read
        base = cap_n;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R3", 1'b0);
        send_byte(8'h44, 1'b1, "R6", 1'b0);
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b0, "R4", 1'b0);
        send_byte({DEV, 1'b0}, 1'b0, "R4", 1'b0);
        bus_stop();
        expect_caps(base, 1, 24'h440000, 12'h000, "R4");

        // R8: partial byte cut by STOP
        base = cap_n;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R3", 1'b0);
        for (int k = 0; k < 4; k++) send_bit(k[0]);
        bus_stop();
        check(!sda_pull_o, "R8", "no pull after cut byte", int'(sda_pull_o), 0);
        expect_caps(base, 0, 24'h0, 12'h0, "R8");

        // R8: partial byte cut by repeated START
        base = cap_n;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R3", 1'b0);
        send_byte(8'h66, 1'b1, "R6", 1'b0);
        for (int k = 0; k < 5; k++) send_bit(1'b1);
        bus_rstart();
        send_byte({DEV, 1'b0}, 1'b1, "R2", 1'b0);
        send_byte(8'h77, 1'b1, "R8", 1'b0);
        bus_stop();
        expect_caps(base, 2, 24'h667700, 12'h000, "R8");

        // R10: short glitches on SCL and SDA
        base = cap_n;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R3", 1'b0);
        send_byte(8'h5A, 1'b1, "R10", 1'b1);
        send_byte(8'hC3, 1'b1, "R10", 1'b1);
        bus_stop();
        expect_caps(base, 2, 24'h5AC300, 12'h010, "R10");

        repeat (20) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule